// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupt Unit

This block sits between the host register interface of a serial controller and its shift engine. It holds a transmit byte FIFO and a receive byte FIFO of `DEPTH` entries each. It derives level flags from them: empty, full, and a threshold flag on each side. Each threshold is a programmable 4-bit value with a maximum of 15. The transmit flag means "room to refill" and the receive flag means "enough to drain".

Every flag and every event from the shift engine lands in one raw status word. A mask register selects which raw bits reach the masked status word. The single interrupt output is the registered OR of the masked bits. A write-one-to-clear register removes latched events, but it cannot hide a level condition that still holds.

A flush request for either FIFO runs for `FLUSH_CYCLES` clock cycles. While a flush runs, every access to that FIFO is ignored. When the flush ends, the FIFO is empty and the request bit clears itself. The host uses a simple word-addressed register port. The shift engine uses a byte pop port on the transmit side and a byte push port on the receive side.

Top module: `fifo_irq_hub`

## Requirements
- R1: Reset state. Both FIFOs are empty and both thresholds are 0. The mask, the control bits and `irq` are 0. RAW (word 6) reads 0x00000033, which is bits 0, 1, 4 and 5.
- R2: Bytes written to TXD (word 1) leave on `tx_data` in write order, with `tx_data` showing the oldest byte while `tx_avail` is 1. A `tx_pop` with `tx_avail` low has no effect. The transmit FIFO holds `DEPTH` bytes (16 by default).
- R3: Transmit level flags in RAW. Bit 0 is 1 while the FIFO is empty. Bit 1 is 1 while its level is less than or equal to the transmit threshold (word 3). Bit 2 is 1 while it holds `DEPTH` bytes.
- R4: A TXD write while the transmit FIFO is full is dropped and sets RAW bit 3. Bit 3 stays set after the FIFO drains, until it is cleared.
- R5: Bytes pushed with `rx_push`/`rx_data` are read from RXD (word 2) oldest first. Each read pops one byte, and a read of an empty FIFO returns 0. In RAW, bit 4 means empty, bit 6 means full, and bit 5 is 1 while the level is greater than or equal to the receive threshold (word 4).
- R6: Writing 1 to bit 7 (transmit) or bit 8 (receive) of CTRL (word 0) starts a flush lasting `FLUSH_CYCLES` cycles. The bit reads 1 while the flush runs and clears itself at the end, leaving that FIFO empty. Pushes, pops and TXD writes to the flushing FIFO are ignored and raise no overrun.
- R7: A one-cycle pulse on `ev_pulse[i]` latches a RAW bit. The bit positions for i = 0..7 are 16, 17, 18, 19, 20, 24, 25 and 28.
- R8: Writing a 1 to a bit of CLR (word 8) clears that bit if it is a latched one (bits 3 and 16 to 28). Level bits 0, 1, 2, 4, 5 and 6 stay set while their condition holds.
- R9: MASK (word 5) stores bits 28..0, and bits 31..29 read 0. MSTAT (word 7) reads RAW AND MASK. RAW bits outside 0x131F007F are always 0.
- R10: `irq` is 1 exactly when MSTAT is nonzero, delayed by one register.
- R11: The threshold words keep only their low 4 bits, so the maximum is 15. They read back the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| h_wr | input | 1 | host register write strobe |
| h_rd | input | 1 | host register read strobe |
| h_addr | input | 4 | host word address |
| h_wdata | input | 32 | host write data |
| h_rdata | output | 32 | host read data, valid the cycle after `h_rd` |
| tx_pop | input | 1 | shift engine takes the head transmit byte |
| tx_data | output | 8 | head of the transmit FIFO |
| tx_avail | output | 1 | transmit FIFO not empty |
| rx_push | input | 1 | shift engine delivers a received byte |
| rx_data | input | 8 | received byte |
| ev_pulse | input | 8 | protocol event pulses to latch |
| irq | output | 1 | interrupt request |

## Verification
The hardest condition to reach is the mix of a latched event bit and a still-true level bit under a single clear write. Proving that the level bit survives requires holding the FIFO in that level while the clear lands. The stimulus first walks every threshold value against every fill level from empty to full, on both FIFOs. It then fires each event pulse alone and clears it with the level bits still standing. It also issues TXD writes during a flush, in the cycle right after the flush request.

// File: rtl/fifo_irq_pkg.sv
`timescale 1ns/1ps
package fifo_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 32;
  localparam int NUM_EV = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_TXD   = 4'd1;
  localparam logic [ADDR_W-1:0] A_RXD   = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXTH  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RXTH  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd6;
  localparam logic [ADDR_W-1:0] A_MSTAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd8;

  localparam int CTRL_FLUSH_LSB = 7;

  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_LOW   = 1;
  localparam int B_TX_FULL  = 2;
  localparam int B_TX_OVR   = 3;
  localparam int B_RX_EMPTY = 4;
  localparam int B_RX_HIGH  = 5;
  localparam int B_RX_FULL  = 6;

  localparam logic [REG_W-1:0] IMPL_BITS = 32'h131F_007F;
  localparam logic [REG_W-1:0] LIVE_BITS = 32'h0000_0077;
  localparam logic [REG_W-1:0] LATCH_BITS = IMPL_BITS & ~LIVE_BITS;
  localparam logic [REG_W-1:0] MASK_BITS = 32'h1FFF_FFFF;

  function automatic int ev_pos(input int idx);
    case (idx)
      0: ev_pos = 16;
      1: ev_pos = 17;
      2: ev_pos = 18;
      3: ev_pos = 19;
      4: ev_pos = 20;
      5: ev_pos = 24;
      6: ev_pos = 25;
      default: ev_pos = 28;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  parameter int AW = $clog2(DEPTH),
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == FULL_LVL);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/flush_seq.sv
`timescale 1ns/1ps
module flush_seq #(
  parameter int CYCLES = 4,
  parameter int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] live_in,
  input  logic [REG_W-1:0] set_in,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] raw_q,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] masked,
  output logic             irq
);
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] latched_nxt;

  assign clr_vec     = clr_we ? (wdata & IMPL_BITS) : '0;
  // a new event wins over a clear in the same cycle
  assign latched_nxt = ((raw_q & ~clr_vec) | set_in) & LATCH_BITS;
  assign masked      = raw_q & mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      raw_q <= (live_in & LIVE_BITS) | latched_nxt;
      if (mask_we) mask_q <= wdata & MASK_BITS;
      irq <= |masked;
    end
  end
endmodule

// File: rtl/fifo_irq_hub.sv
`timescale 1ns/1ps
module fifo_irq_hub
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TH_W = 4,
  parameter int FLUSH_CYCLES = 4,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [REG_W-1:0]  h_wdata,
  output logic [REG_W-1:0]  h_rdata,
  input  logic              tx_pop,
  output logic [7:0]        tx_data,
  output logic              tx_avail,
  input  logic              rx_push,
  input  logic [7:0]        rx_data,
  input  logic [NUM_EV-1:0] ev_pulse,
  output logic              irq
);
  logic wr_ctrl, wr_txd, wr_txth, wr_rxth, wr_mask, wr_clr, rd_rxd;
  assign wr_ctrl = h_wr && (h_addr == A_CTRL);
  assign wr_txd  = h_wr && (h_addr == A_TXD);
  assign wr_txth = h_wr && (h_addr == A_TXTH);
  assign wr_rxth = h_wr && (h_addr == A_RXTH);
  assign wr_mask = h_wr && (h_addr == A_MASK);
  assign wr_clr  = h_wr && (h_addr == A_CLR);
  assign rd_rxd  = h_rd && (h_addr == A_RXD);

  // flush sequencers: index 0 transmit, index 1 receive
  logic [1:0] flush_busy, flush_done;
  for (genvar c = 0; c < 2; c++) begin : g_flush
    flush_seq #(.CYCLES(FLUSH_CYCLES)) u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (wr_ctrl && h_wdata[CTRL_FLUSH_LSB + c]),
      .busy  (flush_busy[c]),
      .done  (flush_done[c])
    );
  end

  logic [LW-1:0] tx_level, rx_level;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]    rx_head;
  logic          tx_push_ok, rx_pop_ok;

  assign tx_push_ok = wr_txd & ~flush_busy[0];
  assign rx_pop_ok  = rd_rxd & ~flush_busy[1];

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush_done[0]),
    .push  (tx_push_ok),
    .din   (h_wdata[7:0]),
    .pop   (tx_pop & ~flush_busy[0]),
    .dout  (tx_data),
    .level (tx_level),
    .empty (tx_empty),
    .full  (tx_full)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush_done[1]),
    .push  (rx_push & ~flush_busy[1]),
    .din   (rx_data),
    .pop   (rx_pop_ok),
    .dout  (rx_head),
    .level (rx_level),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign tx_avail = ~tx_empty & ~flush_busy[0];

  logic [TH_W-1:0] tx_th_q, rx_th_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_th_q <= '0;
      rx_th_q <= '0;
    end else begin
      if (wr_txth) tx_th_q <= h_wdata[TH_W-1:0];
      if (wr_rxth) rx_th_q <= h_wdata[TH_W-1:0];
    end
  end

  logic [REG_W-1:0] live_vec, set_vec;
  always_comb begin
    live_vec = '0;
    live_vec[B_TX_EMPTY] = tx_empty;
    live_vec[B_TX_LOW]   = (tx_level <= LW'(tx_th_q));
    live_vec[B_TX_FULL]  = tx_full;
    live_vec[B_RX_EMPTY] = rx_empty;
    live_vec[B_RX_HIGH]  = (rx_level >= LW'(rx_th_q));
    live_vec[B_RX_FULL]  = rx_full;
  end

  always_comb begin
    set_vec = '0;
    set_vec[B_TX_OVR] = tx_push_ok & tx_full;
    for (int i = 0; i < NUM_EV; i++) set_vec[ev_pos(i)] = ev_pulse[i];
  end

  logic [REG_W-1:0] raw_q, mask_q, masked;
  irq_regs u_irq (
    .clk     (clk),
    .rst     (rst),
    .live_in (live_vec),
    .set_in  (set_vec),
    .clr_we  (wr_clr),
    .mask_we (wr_mask),
    .wdata   (h_wdata),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .masked  (masked),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '0;
    end else if (h_rd) begin
      h_rdata <= '0;
      case (h_addr)
        A_CTRL:  h_rdata[CTRL_FLUSH_LSB +: 2] <= flush_busy;
        A_RXD:   h_rdata[7:0] <= rx_pop_ok && !rx_empty ? rx_head : 8'h00;
        A_TXTH:  h_rdata[TH_W-1:0] <= tx_th_q;
        A_RXTH:  h_rdata[TH_W-1:0] <= rx_th_q;
        A_MASK:  h_rdata <= mask_q;
        A_RAW:   h_rdata <= raw_q;
        A_MSTAT: h_rdata <= masked;
        default: h_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fifo_irq_hub_chk.sv
`timescale 1ns/1ps
module fifo_irq_hub_chk
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              h_wr,
  input logic [ADDR_W-1:0] h_addr,
  input logic [LW-1:0]     tx_level,
  input logic [LW-1:0]     rx_level,
  input logic              tx_full,
  input logic [1:0]        flush_busy,
  input logic [REG_W-1:0]  raw_q,
  input logic [REG_W-1:0]  mask_q,
  input logic              irq
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (h_wr && h_addr == A_TXD && tx_full && !flush_busy[0]) |=> raw_q[B_TX_OVR]);

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_busy[0]) |-> (tx_level == '0));

  assert_flush_empties_rx_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_busy[1]) |-> (rx_level == '0));

  assert_empty_live_R8: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(tx_level) == '0) |-> raw_q[B_TX_EMPTY]);

  assert_holes_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> ((raw_q & ~IMPL_BITS) == '0));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && $past(mask_q) == '0) |-> !irq);
endmodule

bind fifo_irq_hub fifo_irq_hub_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/sim_fifo_irq_hub.sv
`timescale 1ns/1ps
module sim_fifo_irq_hub;
  import fifo_irq_pkg::*;

  localparam int FLUSH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [3:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_avail;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  ev_pulse = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;
  int evp [8] = '{16, 17, 18, 19, 20, 24, 25, 28};

  always #4 clk = ~clk;

  fifo_irq_hub #(.DEPTH(16), .TH_W(4), .FLUSH_CYCLES(FLUSH)) u0 (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [31:0] d);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
    tick(2);
  endtask

  task automatic hr(input logic [3:0] a, output logic [31:0] d);
    h_rd = 1'b1; h_addr = a;
    @(negedge clk);
    h_rd = 1'b0;
    d = h_rdata;
  endtask

  task automatic rxp(input logic [7:0] d);
    rx_push = 1'b1; rx_data = d;
    @(negedge clk);
    rx_push = 1'b0;
    tick(2);
  endtask

  task automatic evp_pulse(input int i);
    ev_pulse = 8'(1 << i);
    @(negedge clk);
    ev_pulse = '0;
    tick(2);
  endtask

  task automatic flushf(input logic [31:0] bits);
    hw(A_CTRL, bits);
    tick(FLUSH + 2);
  endtask

  initial begin
    tick(200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(3);

    // R1 reset state
    hr(A_RAW, v);  chk("R1 raw", v, 32'h33);
    hr(A_MASK, v); chk("R1 mask", v, 0);
    hr(A_CTRL, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 avail", {31'd0, tx_avail}, 0);

    // R3 / R11 transmit threshold sweep
    for (int t = 0; t < 16; t++) begin
      hw(A_TXTH, 32'hFFFF_FFF0 | t);
      hr(A_TXTH, v); chk("R11 txth", v, t);
      flushf(32'h80);
      for (int l = 0; l <= 16; l++) begin
        hr(A_RAW, v);
        chk("R3 tx flags", {29'd0, v[2:0]}, {29'd0, l == 16, l <= t, l == 0});
        if (l < 16) hw(A_TXD, l);
      end
    end

    // R5 / R11 receive threshold sweep
    for (int t = 0; t < 16; t++) begin
      hw(A_RXTH, 32'hABCD_0000 | t);
      hr(A_RXTH, v); chk("R11 rxth", v, t);
      flushf(32'h100);
      for (int l = 0; l <= 16; l++) begin
        hr(A_RAW, v);
        chk("R5 rx flags", {29'd0, v[6:4]}, {29'd0, l == 16, l >= t, l == 0});
        if (l < 16) rxp(8'(l));
      end
    end

    // R2 / R4 transmit order and overrun
    hw(A_TXTH, 0); hw(A_RXTH, 0);
    flushf(32'h180);
    for (int i = 0; i < 16; i++) hw(A_TXD, (i * 37 + 5) & 8'hFF);
    hr(A_RAW, v); chk("R4 no overrun yet", {31'd0, v[3]}, 0);
    hw(A_TXD, 32'hEE);
    hr(A_RAW, v); chk("R4 overrun set", {31'd0, v[3]}, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R2 avail", {31'd0, tx_avail}, 1);
      chk("R2 order", {24'd0, tx_data}, (i * 37 + 5) & 8'hFF);
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0; tick(1);
    end
    chk("R2 drained", {31'd0, tx_avail}, 0);
    tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0; tick(2);
    hr(A_RAW, v); chk("R4 overrun held", {31'd0, v[3]}, 1);
    chk("R2 empty pop", {31'd0, v[0]}, 1);
    hw(A_CLR, 32'h8);
    hr(A_RAW, v); chk("R4 overrun cleared", v, 32'h33);

    // R5 receive data order
    for (int i = 0; i < 16; i++) rxp(8'(i * 11 + 3));
    for (int i = 0; i < 16; i++) begin
      hr(A_RXD, v); chk("R5 rx order", v, (i * 11 + 3) & 8'hFF);
    end
    hr(A_RXD, v); chk("R5 empty read", v, 0);

    // R6 flush with ignored access
    for (int i = 0; i < 3; i++) hw(A_TXD, i);
    h_wr = 1'b1; h_addr = A_CTRL; h_wdata = 32'h80;
    @(negedge clk);
    h_addr = A_TXD; h_wdata = 32'h55;
    @(negedge clk);
    h_wr = 1'b0;
    hr(A_CTRL, v); chk("R6 busy readback", v, 32'h80);
    tick(FLUSH + 2);
    hr(A_CTRL, v); chk("R6 self clear", v, 0);
    hr(A_RAW, v); chk("R6 tx emptied, no overrun", v, 32'h33);
    rxp(8'h1); rxp(8'h2);
    rx_push = 1'b1; rx_data = 8'h9; h_wr = 1'b1; h_addr = A_CTRL; h_wdata = 32'h100;
    @(negedge clk);
    h_wr = 1'b0;
    @(negedge clk);
    rx_push = 1'b0;
    tick(FLUSH + 2);
    hr(A_RAW, v); chk("R6 rx emptied", v, 32'h33);

    // R7 / R8 event latching and clearing
    for (int i = 0; i < 8; i++) begin
      evp_pulse(i);
      hr(A_RAW, v); chk("R7 event bit", v, 32'h33 | (32'h1 << evp[i]));
      hw(A_CLR, 32'h1 << evp[i]);
      hr(A_RAW, v); chk("R8 event cleared", v, 32'h33);
    end
    ev_pulse = 8'hFF; @(negedge clk); ev_pulse = '0; tick(2);
    hr(A_RAW, v); chk("R7 all events", v, 32'h131F_0033);
    hw(A_CLR, 32'hFFFF_FFFF);
    hr(A_RAW, v); chk("R8 live bits persist", v, 32'h33);

    // R9 / R10 mask, masked status, interrupt
    hw(A_MASK, 32'hFFFF_FFFF);
    hr(A_MASK, v); chk("R9 mask reserved", v, 32'h1FFF_FFFF);
    hr(A_MSTAT, v); chk("R9 masked", v, 32'h33);
    chk("R10 irq on", {31'd0, irq}, 1);
    hw(A_MASK, 32'h0200_0008);
    hr(A_MSTAT, v); chk("R9 masked none", v, 0);
    chk("R10 irq off", {31'd0, irq}, 0);
    evp_pulse(6);
    hr(A_MSTAT, v); chk("R9 masked bus event", v, 32'h0200_0000);
    chk("R10 irq event", {31'd0, irq}, 1);
    hw(A_CLR, 32'h0200_0000);
    chk("R10 irq cleared", {31'd0, irq}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule